// File: doc/BRIEF.md
# Branch Target and Link Unit

This unit resolves every control-transfer form of a 16-bit compact instruction encoding. Each cycle it takes a decoded branch kind, the raw opcode, the pipelined program counter, the current link value, a register operand and the four condition flags. One clock later it presents the next program counter and the next link value, each with its own write strobe, and it keeps the instruction-set state bit. The unit covers four forms: short branches guarded by a condition code, unconditional relative jumps, a subroutine call split over two halfwords, and a jump through a register that also picks the instruction-set state.

The long call works in two steps. The first halfword adds the upper part of the displacement to the PC and parks the result in the link register. The second halfword adds its own lower part to that parked value to form the target. It then leaves the return address, PC minus one, in the link register. The caller feeds the link output back to the link input between the two halves. Refilling the pipeline after a taken branch is left to the surrounding core.

Top module: `brn_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, both write strobes are low and the state bit reads 1.
- R2: The kind code is 3'd1 for a conditional branch. Opcode bits [11:8] select the condition: 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C & !Z), 9 LS (!C | Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z & N==V), 13 LE (Z | N!=V). The flags input is {N,Z,C,V}. When the condition holds, the new PC is PC plus twice the sign-extended opcode bits [7:0], and the PC strobe is high.
- R3: A conditional branch whose condition fails raises no strobe. Condition codes 14 and 15 never branch.
- R4: The kind code is 3'd2 for a jump. The new PC is PC plus twice the sign-extended opcode bits [10:0]. The PC strobe is high and the link strobe is low.
- R5: The kind code is 3'd3 for the first call half. The new link value is PC plus the sign-extended opcode bits [10:0] shifted left by 12. The link strobe is high and the PC strobe is low.
- R6: The kind code is 3'd4 for the second call half. The new PC is the link input plus the zero-extended opcode bits [10:0] shifted left by 1. The new link value is PC minus 1, and both strobes are high.
- R7: The kind code is 3'd5 for exchange. Opcode bits [6:3] give the register index. The state bit takes bit 0 of the source value. The new PC is the source value with bit 0 cleared, and the PC strobe is high.
- R8: When the exchange index is 15, the source value is the PC input and the register operand is ignored. Bit 1 of the PC is also subtracted, as a value of 2, from the target.
- R9: Results appear one clock after the inputs are sampled, and each strobe lasts one cycle per request. The kind code 3'd0, and the unused codes 6 and 7, raise no strobe and leave the state bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind | input | 3 | Decoded branch kind |
| op | input | 16 | Raw instruction halfword |
| pc_in | input | 32 | Pipelined program counter |
| lr_in | input | 32 | Current link register value |
| rv_in | input | 32 | Value of the register named by the exchange index |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| pc_new | output | 32 | Next program counter |
| pc_we | output | 1 | Program counter write strobe |
| lr_new | output | 32 | Next link register value |
| lr_we | output | 1 | Link register write strobe |
| state | output | 1 | Instruction-set state bit |

## Verification
Every result of this unit (new PC, new link value, both strobes and the state bit) is due exactly one rising edge after the inputs it depends on are presented. The bench drives inputs on a falling edge and samples all outputs on the next falling edge, so each check falls half a period after the single register stage. Strobe checks also follow a taken branch with an idle cycle and sample one more falling edge later. This confirms that the strobe has dropped in the very next cycle.

// File: rtl/brn_pkg.sv
package brn_pkg;

    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        BK_NONE    = 3'd0,
        BK_COND    = 3'd1,
        BK_JUMP    = 3'd2,
        BK_CALL_HI = 3'd3,
        BK_CALL_LO = 3'd4,
        BK_EXCH    = 3'd5
    } bkind_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13
    } ccode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic            pc_we;
        logic [XLEN-1:0] pc;
        logic            lr_we;
        logic [XLEN-1:0] lr;
        logic            st_we;
        logic            st;
    } bres_t;

    function automatic logic cond_holds(input logic [3:0] code, input flags_t f);
        logic r;
        case (code)
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brn_cond.sv
module brn_cond
    import brn_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    input  flags_t            fl,
    output logic              taken
);
    always_comb begin
        taken = cond_holds(code, fl);
    end
endmodule

// File: rtl/brn_target.sv
module brn_target
    import brn_pkg::*;
#(
    parameter int W          = 32,
    parameter int OP_W       = 16,
    parameter int SHORT_W    = 8,
    parameter int LONG_W     = 11,
    parameter int CALL_SHIFT = 12,
    parameter int IDX_LSB    = 3,
    parameter int IDX_W      = 4
) (
    input  logic [2:0]      kind,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    pc_in,
    input  logic [W-1:0]    lr_in,
    input  logic [W-1:0]    rv_in,
    input  logic            cond_ok,
    output bres_t           res
);
    localparam int SHORT_PAD = W - SHORT_W - 1;
    localparam int LONG_PAD  = W - LONG_W - 1;
    localparam int HI_PAD    = W - LONG_W - CALL_SHIFT;

    logic [W-1:0]     short_ofs, jump_ofs, hi_ofs, lo_ofs;
    logic [IDX_W-1:0] xidx;
    logic             from_pc;
    logic [W-1:0]     xsrc, xmis, xtgt;

    assign short_ofs = {{SHORT_PAD{op[SHORT_W-1]}}, op[SHORT_W-1:0], 1'b0};
    assign jump_ofs  = {{LONG_PAD{op[LONG_W-1]}}, op[LONG_W-1:0], 1'b0};
    assign hi_ofs    = {{HI_PAD{op[LONG_W-1]}}, op[LONG_W-1:0], {CALL_SHIFT{1'b0}}};
    assign lo_ofs    = {{LONG_PAD{1'b0}}, op[LONG_W-1:0], 1'b0};

    assign xidx    = op[IDX_LSB +: IDX_W];
    assign from_pc = (xidx == {IDX_W{1'b1}});
    assign xsrc    = from_pc ? pc_in : rv_in;
    assign xmis    = from_pc ? {{(W-2){1'b0}}, xsrc[1], 1'b0} : '0;
    assign xtgt    = {xsrc[W-1:1], 1'b0} - xmis;

    always_comb begin
        res       = '0;
        res.pc    = pc_in;
        res.lr    = lr_in;
        case (kind)
            BK_COND: begin
                res.pc_we = cond_ok;
                res.pc    = pc_in + short_ofs;
            end
            BK_JUMP: begin
                res.pc_we = 1'b1;
                res.pc    = pc_in + jump_ofs;
            end
            BK_CALL_HI: begin
                res.lr_we = 1'b1;
                res.lr    = pc_in + hi_ofs;
            end
            BK_CALL_LO: begin
                res.pc_we = 1'b1;
                res.pc    = lr_in + lo_ofs;
                res.lr_we = 1'b1;
                res.lr    = pc_in - W'(1);
            end
            BK_EXCH: begin
                res.pc_we = 1'b1;
                res.pc    = xtgt;
                res.st_we = 1'b1;
                res.st    = xsrc[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/brn_unit.sv
module brn_unit
    import brn_pkg::*;
#(
    parameter int W          = XLEN,
    parameter int OP_W       = 16,
    parameter int SHORT_W    = 8,
    parameter int LONG_W     = 11,
    parameter int CALL_SHIFT = 12,
    parameter int COND_LSB   = 8,
    parameter int CODE_W     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      kind,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    pc_in,
    input  logic [W-1:0]    lr_in,
    input  logic [W-1:0]    rv_in,
    input  logic [3:0]      flags,
    output logic [W-1:0]    pc_new,
    output logic            pc_we,
    output logic [W-1:0]    lr_new,
    output logic            lr_we,
    output logic            state
);
    logic  cond_ok;
    bres_t nxt;

    brn_cond #(.CODE_W(CODE_W)) u_cond (
        .code  (op[COND_LSB +: CODE_W]),
        .fl    (flags_t'(flags)),
        .taken (cond_ok)
    );

    brn_target #(
        .W(W), .OP_W(OP_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W),
        .CALL_SHIFT(CALL_SHIFT), .IDX_LSB(3), .IDX_W(4)
    ) u_tgt (
        .kind    (kind),
        .op      (op),
        .pc_in   (pc_in),
        .lr_in   (lr_in),
        .rv_in   (rv_in),
        .cond_ok (cond_ok),
        .res     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_new <= '0;
            pc_we  <= 1'b0;
            lr_new <= '0;
            lr_we  <= 1'b0;
            state  <= 1'b1;
        end else begin
            pc_new <= nxt.pc;
            pc_we  <= nxt.pc_we;
            lr_new <= nxt.lr;
            lr_we  <= nxt.lr_we;
            if (nxt.st_we) state <= nxt.st;
        end
    end
endmodule

// File: rtl/brn_unit_chk.sv
module brn_unit_chk #(
    parameter int W    = 32,
    parameter int OP_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      kind,
    input logic [OP_W-1:0] op,
    input logic [W-1:0]    pc_in,
    input logic [W-1:0]    pc_new,
    input logic            pc_we,
    input logic [W-1:0]    lr_new,
    input logic            lr_we,
    input logic            state
);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd0) |=> (!pc_we && !lr_we && $stable(state)));

    assert_never_codes_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd1 && op[11:9] == 3'b111) |=> !pc_we);

    assert_call_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd3) |=> (lr_we && !pc_we));

    assert_call_lo_R6: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd4) |=> (pc_we && lr_we && lr_new == $past(pc_in) - W'(1)));

    assert_exch_even_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd5) |=> (pc_we && !lr_we && pc_new[0] == 1'b0));

    assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd2) |=> (pc_we && !lr_we && $stable(state)));

    assert_state_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (kind != 3'd5) |=> $stable(state));
endmodule

bind brn_unit brn_unit_chk #(.W(W), .OP_W(OP_W)) u_chk (
    .clk(clk), .rst(rst), .kind(kind), .op(op), .pc_in(pc_in),
    .pc_new(pc_new), .pc_we(pc_we), .lr_new(lr_new), .lr_we(lr_we),
    .state(state)
);

// File: tb/sim_brn_unit.sv
module sim_brn_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  kind;
    logic [15:0] op;
    logic [31:0] pc_in, lr_in, rv_in;
    logic [3:0]  flags;
    logic [31:0] pc_new, lr_new;
    logic        pc_we, lr_we, state;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    brn_unit u0 (
        .clk(clk), .rst(rst), .kind(kind), .op(op), .pc_in(pc_in),
        .lr_in(lr_in), .rv_in(rv_in), .flags(flags), .pc_new(pc_new),
        .pc_we(pc_we), .lr_new(lr_new), .lr_we(lr_we), .state(state)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [2:0]  k;
        logic [15:0] o;
        logic [31:0] pc;
        logic [31:0] lr;
        logic [31:0] rv;
        logic [3:0]  f;
        logic        epw;
        logic [31:0] epc;
        logic        elw;
        logic [31:0] elr;
        logic        est;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{8'd2, 3'd1, 16'hD005, 32'h100,  32'h0,    32'h0,        4'b0100, 1'b1, 32'h10A,      1'b0, 32'h0,    1'b1}, // R2 EQ taken
        '{8'd3, 3'd1, 16'hD005, 32'h100,  32'h0,    32'h0,        4'b0000, 1'b0, 32'h0,        1'b0, 32'h0,    1'b1}, // R3 EQ fails
        '{8'd2, 3'd1, 16'hD1FE, 32'h200,  32'h0,    32'h0,        4'b0000, 1'b1, 32'h1FC,      1'b0, 32'h0,    1'b1}, // R2 NE back
        '{8'd2, 3'd1, 16'hDA10, 32'h300,  32'h0,    32'h0,        4'b1001, 1'b1, 32'h320,      1'b0, 32'h0,    1'b1}, // R2 GE
        '{8'd2, 3'd1, 16'hDB80, 32'h1000, 32'h0,    32'h0,        4'b1000, 1'b1, 32'hF00,      1'b0, 32'h0,    1'b1}, // R2 LT
        '{8'd3, 3'd1, 16'hD804, 32'h100,  32'h0,    32'h0,        4'b0110, 1'b0, 32'h0,        1'b0, 32'h0,    1'b1}, // R3 HI fails
        '{8'd2, 3'd1, 16'hDC01, 32'h40,   32'h0,    32'h0,        4'b0000, 1'b1, 32'h42,       1'b0, 32'h0,    1'b1}, // R2 GT
        '{8'd2, 3'd1, 16'hDD7F, 32'h40,   32'h0,    32'h0,        4'b0100, 1'b1, 32'h13E,      1'b0, 32'h0,    1'b1}, // R2 LE
        '{8'd3, 3'd1, 16'hDE05, 32'h40,   32'h0,    32'h0,        4'b0000, 1'b0, 32'h0,        1'b0, 32'h0,    1'b1}, // R3 code 14
        '{8'd4, 3'd2, 16'hE400, 32'h2000, 32'h0,    32'h0,        4'b0000, 1'b1, 32'h1800,     1'b0, 32'h0,    1'b1}, // R4 back
        '{8'd4, 3'd2, 16'hE3FF, 32'h2000, 32'h0,    32'h0,        4'b0000, 1'b1, 32'h27FE,     1'b0, 32'h0,    1'b1}, // R4 fwd
        '{8'd5, 3'd3, 16'hF001, 32'h8000, 32'h0,    32'h0,        4'b0000, 1'b0, 32'h0,        1'b1, 32'h9000, 1'b1}, // R5 up
        '{8'd5, 3'd3, 16'hF7FF, 32'h8000, 32'h0,    32'h0,        4'b0000, 1'b0, 32'h0,        1'b1, 32'h7000, 1'b1}, // R5 down
        '{8'd6, 3'd4, 16'hF810, 32'h8004, 32'h9000, 32'h0,        4'b0000, 1'b1, 32'h9020,     1'b1, 32'h8003, 1'b1}, // R6
        '{8'd7, 3'd5, 16'h4718, 32'h0,    32'h0,    32'h08000001, 4'b0000, 1'b1, 32'h08000000, 1'b0, 32'h0,    1'b1}, // R7 odd
        '{8'd7, 3'd5, 16'h4710, 32'h0,    32'h0,    32'h03000006, 4'b0000, 1'b1, 32'h03000006, 1'b0, 32'h0,    1'b0}, // R7 even
        '{8'd8, 3'd5, 16'h4778, 32'h106,  32'h0,    32'hFFFFFFFF, 4'b0000, 1'b1, 32'h104,      1'b0, 32'h0,    1'b0}, // R8 misalign
        '{8'd8, 3'd5, 16'h4778, 32'h205,  32'h0,    32'hFFFFFFFF, 4'b0000, 1'b1, 32'h204,      1'b0, 32'h0,    1'b1}, // R8 aligned
        '{8'd9, 3'd0, 16'hDFFF, 32'h300,  32'h0,    32'h12345677, 4'b1111, 1'b0, 32'h0,        1'b0, 32'h0,    1'b1}  // R9 idle
    };

    task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [15:0] o, input logic [31:0] p,
                         input logic [31:0] l, input logic [31:0] r, input logic [3:0] f);
        kind = k; op = o; pc_in = p; lr_in = l; rv_in = r; flags = f;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        drive(3'd2, 16'hE001, 32'h100, 32'h0, 32'h0, 4'b0000);
        repeat (3) @(negedge clk);
        // R1: strobes low and state 1 while reset holds even with a jump on the inputs
        chk(1, "pc_we in reset", {31'b0, pc_we}, 32'd0);
        chk(1, "lr_we in reset", {31'b0, lr_we}, 32'd0);
        chk(1, "state in reset", {31'b0, state}, 32'd1);
        drive(3'd0, 16'h0, 32'h0, 32'h0, 32'h0, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        chk(1, "pc_we after reset", {31'b0, pc_we}, 32'd0);
        chk(1, "state after reset", {31'b0, state}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].k, TBL[i].o, TBL[i].pc, TBL[i].lr, TBL[i].rv, TBL[i].f);
            @(negedge clk);
            chk(TBL[i].rq, "pc_we", {31'b0, pc_we}, {31'b0, TBL[i].epw});
            if (TBL[i].epw) chk(TBL[i].rq, "pc_new", pc_new, TBL[i].epc);
            chk(TBL[i].rq, "lr_we", {31'b0, lr_we}, {31'b0, TBL[i].elw});
            if (TBL[i].elw) chk(TBL[i].rq, "lr_new", lr_new, TBL[i].elr);
            chk(TBL[i].rq, "state", {31'b0, state}, {31'b0, TBL[i].est});
        end

        // R9: a strobe lasts a single cycle when idle follows a jump
        drive(3'd2, 16'hE010, 32'h500, 32'h0, 32'h0, 4'b0000);
        @(negedge clk);
        chk(4, "jump pc_new", pc_new, 32'h520);
        drive(3'd0, 16'hE010, 32'h500, 32'h0, 32'h0, 4'b0000);
        @(negedge clk);
        chk(9, "pc_we drops", {31'b0, pc_we}, 32'd0);

        // R9: unused kind code 6 does nothing
        drive(3'd6, 16'h4778, 32'h101, 32'h0, 32'h0, 4'b0000);
        @(negedge clk);
        chk(9, "kind6 pc_we", {31'b0, pc_we}, 32'd0);
        chk(9, "kind6 lr_we", {31'b0, lr_we}, 32'd0);
        chk(9, "kind6 state", {31'b0, state}, 32'd1);

        // R6: chained call, link output fed back as link input
        drive(3'd3, 16'hF002, 32'h1000, 32'h0, 32'h0, 4'b0000);
        @(negedge clk);
        chk(5, "chain hi lr", lr_new, 32'h3000);
        drive(3'd4, 16'hF8FF, 32'h1002, lr_new, 32'h0, 4'b0000);
        @(negedge clk);
        chk(6, "chain lo pc", pc_new, 32'h31FE);
        chk(6, "chain lo lr", lr_new, 32'h1001);

        // R3: code 15 never branches even with all flags set
        drive(3'd1, 16'hDF01, 32'h40, 32'h0, 32'h0, 4'b1111);
        @(negedge clk);
        chk(3, "code15 pc_we", {31'b0, pc_we}, 32'd0);

        // R1: reset mid-run returns state to 1
        drive(3'd5, 16'h4710, 32'h0, 32'h0, 32'h2, 4'b0000);
        @(negedge clk);
        chk(7, "state cleared", {31'b0, state}, 32'd0);
        rst = 1'b1;
        drive(3'd0, 16'h0, 32'h0, 32'h0, 32'h0, 4'b0000);
        @(negedge clk);
        chk(1, "state after re-reset", {31'b0, state}, 32'd1);
        rst = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule